// File: doc/BRIEF.md
# Flash Command Sequence Decoder

This block sits beside the array of a parallel NOR-style flash and watches its bus write cycles. Each write is an address and a 16-bit data word. The block decodes multi-cycle command sequences from these writes and chooses what the read path returns: array data, identification data or status. It also fires the start strobes for single-word and double-word programming, together with the latched target address and data.

The block keeps a 16-bit configuration register. Bit 10 of that register tells the reset pin whether it also performs power-down. The block also tracks a bypass mode in which the two unlock writes are skipped. While an identification read is active, the block drives the read data from the low address bits, the block-protect vector and the configuration register. The array, the program timing and the status word are outside this block. Program completion arrives as a one-cycle `done` pulse.

Top module: `flash_cmd_decoder`

## Requirements
- R1: After reset, read_mode is 0 (array), busy, bypass and both start strobes are 0, and cfg_word is 0000h.
- R2: A normal command is AAh written to word address 555h, then 55h to 2AAh, then the command byte to 555h. Only address bits 10..0 and data bits 7..0 are compared. The command bytes are 90h (identify), 60h (configuration), 20h (bypass), A0h (program) and 40h (double program).
- R3: A write that breaks a sequence returns the machine to idle with read_mode 0. It causes no start strobe and no configuration change.
- R4: After 90h, read_mode is 1. An identify read with rd_addr[1:0]=00 returns 00h:MFR_CODE and with 01 returns 00h:DEV_CODE. Any read with rd_addr[7:2] nonzero returns 0000h.
- R5: An identify read with rd_addr[1:0]=10 returns 0001h when blk_prot[rd_addr[20:12]] is set and 0000h when it is clear.
- R6: After 60h, a write with data 03h loads wr_addr[15:0] into cfg_word, and any other data leaves cfg_word unchanged. An identify read with rd_addr[1:0]=11 returns the full cfg_word. rp_pdown_en equals cfg_word bit 10.
- R7: The fourth write of a program sequence pulses prog_start for one cycle, starting the cycle after that write. It also latches prog_addr and sets prog_data0 = wr_data AND arr_word.
- R8: In a double program, the fourth write latches prog_addr and prog_data0, and the fifth latches prog_data1 and pulses dprog_start. If the fifth address differs from the fourth in any bit above bit 0, the sequence aborts with no strobe.
- R9: Command 20h sets bypass. In bypass, A0h or 40h written to any address replaces the first three writes of the program or double program sequence.
- R10: In bypass, 90h followed by 00h clears bypass and returns to array reads. 90h followed by any other value leaves bypass set.
- R11: busy rises together with either start strobe and falls after a done pulse. Writes made while busy is set have no effect.
- R12: While busy, reads whose top address bit (bank) equals that of prog_addr give read_mode 2 (status). Reads in the other bank give read_mode 0.
- R13: In identify mode, any write that is not AAh to 555h (for example F0h) returns read_mode to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Bus write cycle, one clock per write |
| wr_addr | input | ADDR_W | Word address of the write |
| wr_data | input | 16 | Data of the write |
| arr_word | input | 16 | Current array contents at wr_addr |
| done | input | 1 | Program completion pulse |
| rd_addr | input | ADDR_W | Address of the current read |
| blk_prot | input | 2**(ADDR_W-BLK_LSB) | Protect bit for each block |
| read_mode | output | 2 | 0 array, 1 identify, 2 status |
| as_data | output | 16 | Identify read data |
| prog_start | output | 1 | Single-word program start strobe |
| dprog_start | output | 1 | Double-word program start strobe |
| prog_addr | output | ADDR_W | Latched program address |
| prog_data0 | output | 16 | First merged program word |
| prog_data1 | output | 16 | Second merged program word |
| busy | output | 1 | Program in progress |
| bypass | output | 1 | Bypass mode active |
| cfg_word | output | 16 | Configuration register |
| rp_pdown_en | output | 1 | Reset pin also powers down |

## Verification
Some rules are checked by assertions on every cycle. The sequencer state must stay frozen while busy. The two start strobes must never be high together, and busy must be high whenever either strobe is. Merged program words may only clear bits of the old word. The configuration register may change only on its load event, and bypass may be left only from the exit state. Other behaviours depend on the values decoded across a whole sequence, and only the bench scenarios can show them. These are the identify read decode, the block-protect lookup, the abort paths, the dword address-pair rule, the bypass short forms and the bank-based status selection.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_UNLK1,
    S_UNLK2,
    S_CFG,
    S_PG,
    S_DPG0,
    S_DPG1,
    S_BYX
  } seq_state_e;

  localparam logic [1:0] RD_ARRAY  = 2'd0;
  localparam logic [1:0] RD_ASEL   = 2'd1;
  localparam logic [1:0] RD_STATUS = 2'd2;

  localparam logic [7:0] CMD_KEY1   = 8'hAA;
  localparam logic [7:0] CMD_KEY2   = 8'h55;
  localparam logic [7:0] CMD_ASEL   = 8'h90;
  localparam logic [7:0] CMD_CFG    = 8'h60;
  localparam logic [7:0] CMD_BYP    = 8'h20;
  localparam logic [7:0] CMD_PG     = 8'hA0;
  localparam logic [7:0] CMD_DPG    = 8'h40;
  localparam logic [7:0] CMD_CFG_OK = 8'h03;
  localparam logic [7:0] CMD_BYX_OK = 8'h00;

  localparam int          KEY_AW  = 11;
  localparam logic [10:0] ADR_KEY1 = 11'h555;
  localparam logic [10:0] ADR_KEY2 = 11'h2AA;

  // Programming can only turn ones into zeros.
  function automatic logic [15:0] clear_only(input logic [15:0] old_w,
                                             input logic [15:0] new_w);
    return old_w & new_w;
  endfunction

  function automatic logic key_hit(input logic [10:0] a, input logic [10:0] want,
                                   input logic [7:0] d, input logic [7:0] dwant);
    return (a == want) && (d == dwant);
  endfunction

endpackage

// File: rtl/fcd_seq.sv
module fcd_seq
  import flash_cmd_pkg::*;
#(
  parameter int ADDR_W = 21
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        cmd,
  input  logic [ADDR_W-2:0] first_hi,
  input  logic              busy_i,
  output logic              as_mode_o,
  output logic              bypass_o,
  output logic              ev_pg,
  output logic              ev_dpg0,
  output logic              ev_dpg1,
  output logic              ev_cfg
);

  seq_state_e state_q, state_n;
  logic       as_q, as_n;
  logic       by_q, by_n;
  logic       accept;
  logic [KEY_AW-1:0] key_addr;

  assign accept   = wr_en && !busy_i;
  assign key_addr = wr_addr[KEY_AW-1:0];

  always_comb begin
    state_n = state_q;
    as_n    = as_q;
    by_n    = by_q;
    ev_pg   = 1'b0;
    ev_dpg0 = 1'b0;
    ev_dpg1 = 1'b0;
    ev_cfg  = 1'b0;
    if (accept) begin
      case (state_q)
        S_IDLE: begin
          if (by_q) begin
            if (cmd == CMD_PG)        state_n = S_PG;
            else if (cmd == CMD_DPG)  state_n = S_DPG0;
            else if (cmd == CMD_ASEL) state_n = S_BYX;
          end else if (key_hit(key_addr, ADR_KEY1, cmd, CMD_KEY1)) begin
            state_n = S_UNLK1;
          end else begin
            as_n = 1'b0;
          end
        end
        S_UNLK1: begin
          if (key_hit(key_addr, ADR_KEY2, cmd, CMD_KEY2)) state_n = S_UNLK2;
          else begin
            state_n = S_IDLE;
            as_n    = 1'b0;
          end
        end
        S_UNLK2: begin
          state_n = S_IDLE;
          as_n    = 1'b0;
          if (key_addr == ADR_KEY1) begin
            case (cmd)
              CMD_ASEL: as_n    = 1'b1;
              CMD_CFG:  state_n = S_CFG;
              CMD_BYP:  by_n    = 1'b1;
              CMD_PG:   state_n = S_PG;
              CMD_DPG:  state_n = S_DPG0;
              default:  state_n = S_IDLE;
            endcase
          end
        end
        S_CFG: begin
          state_n = S_IDLE;
          ev_cfg  = (cmd == CMD_CFG_OK);
        end
        S_PG: begin
          state_n = S_IDLE;
          ev_pg   = 1'b1;
        end
        S_DPG0: begin
          state_n = S_DPG1;
          ev_dpg0 = 1'b1;
        end
        S_DPG1: begin
          state_n = S_IDLE;
          ev_dpg1 = (wr_addr[ADDR_W-1:1] == first_hi);
        end
        S_BYX: begin
          state_n = S_IDLE;
          if (cmd == CMD_BYX_OK) by_n = 1'b0;
        end
        default: state_n = S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      as_q    <= 1'b0;
      by_q    <= 1'b0;
    end else begin
      state_q <= state_n;
      as_q    <= as_n;
      by_q    <= by_n;
    end
  end

  assign as_mode_o = as_q;
  assign bypass_o  = by_q;

  // R11: writes during a program leave the sequencer untouched
  p_busy_freeze_r11: assert property (@(posedge clk) disable iff (!rst_n)
    busy_i |=> $stable(state_q));

  // R10: bypass is only left from the exit-confirm step
  p_bypass_exit_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(by_q) |-> $past(state_q) == S_BYX);

  // R9: identify mode and bypass never coexist
  p_mode_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(as_q && by_q));

  // R8: second data step is reached only through the first
  p_dpg_order_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_DPG1) |-> ($past(state_q) == S_DPG0 || $past(state_q) == S_DPG1));

endmodule

// File: rtl/fcd_prog_latch.sv
module fcd_prog_latch
  import flash_cmd_pkg::*;
#(
  parameter int ADDR_W = 21
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ev_pg,
  input  logic              ev_dpg0,
  input  logic              ev_dpg1,
  input  logic              done,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [15:0]       wr_data,
  input  logic [15:0]       arr_word,
  output logic [ADDR_W-1:0] prog_addr,
  output logic [15:0]       prog_data0,
  output logic [15:0]       prog_data1,
  output logic              prog_start,
  output logic              dprog_start,
  output logic              busy
);

  logic [15:0] merged;
  assign merged = clear_only(arr_word, wr_data);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prog_addr   <= '0;
      prog_data0  <= '0;
      prog_data1  <= '0;
      prog_start  <= 1'b0;
      dprog_start <= 1'b0;
      busy        <= 1'b0;
    end else begin
      prog_start  <= 1'b0;
      dprog_start <= 1'b0;
      if (ev_pg || ev_dpg0) begin
        prog_addr  <= wr_addr;
        prog_data0 <= merged;
      end
      if (ev_dpg1) prog_data1 <= merged;
      if (ev_pg || ev_dpg1) begin
        prog_start  <= ev_pg;
        dprog_start <= ev_dpg1;
        busy        <= 1'b1;
      end else if (done) begin
        busy <= 1'b0;
      end
    end
  end

  // R7: one strobe at a time
  p_strobe_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({prog_start, dprog_start}));

  // R11: every strobe is covered by busy
  p_start_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (prog_start || dprog_start) |-> busy);

  // R7: the merged word never sets a bit the array had cleared
  p_clear_only_r7: assert property (@(posedge clk) disable iff (!rst_n)
    prog_start |-> ((prog_data0 & ~$past(arr_word)) == 16'h0000));

  // R11: completion ends the busy period
  p_done_clears_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && done) |=> !busy);

endmodule

// File: rtl/fcd_cfg_reg.sv
module fcd_cfg_reg (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ev_cfg,
  input  logic [15:0] load_val,
  output logic [15:0] cfg_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cfg_q <= 16'h0000;
    else if (ev_cfg) cfg_q <= load_val;
  end

  // R6: the register only moves on its load event
  p_cfg_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !ev_cfg |=> $stable(cfg_q));

endmodule

// File: rtl/fcd_asel_mux.sv
module fcd_asel_mux #(
  parameter int          ADDR_W   = 21,
  parameter int          BLK_LSB  = 12,
  parameter logic [7:0]  MFR_CODE = 8'h20,
  parameter logic [7:0]  DEV_CODE = 8'hA0,
  localparam int         NUM_BLK  = 2 ** (ADDR_W - BLK_LSB)
) (
  input  logic [ADDR_W-1:0]  rd_addr,
  input  logic [NUM_BLK-1:0] blk_prot,
  input  logic [15:0]        cfg_q,
  output logic [15:0]        as_data
);

  logic [ADDR_W-BLK_LSB-1:0] blk_idx;
  logic                      pad_ok;
  logic                      unused_rd_mid;

  assign blk_idx       = rd_addr[ADDR_W-1:BLK_LSB];
  assign pad_ok        = (rd_addr[7:2] == 6'd0);
  assign unused_rd_mid = ^rd_addr[BLK_LSB-1:8];

  always_comb begin
    as_data = 16'h0000;
    if (pad_ok) begin
      case (rd_addr[1:0])
        2'b00:   as_data = {8'h00, MFR_CODE};
        2'b01:   as_data = {8'h00, DEV_CODE};
        2'b10:   as_data = {15'h0000, blk_prot[blk_idx]};
        default: as_data = cfg_q;
      endcase
    end
  end

endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder
  import flash_cmd_pkg::*;
#(
  parameter int         ADDR_W   = 21,
  parameter int         BLK_LSB  = 12,
  parameter int         BANK_W   = 1,
  parameter logic [7:0] MFR_CODE = 8'h20,
  parameter logic [7:0] DEV_CODE = 8'hA0,
  localparam int        NUM_BLK  = 2 ** (ADDR_W - BLK_LSB)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [ADDR_W-1:0]  wr_addr,
  input  logic [15:0]        wr_data,
  input  logic [15:0]        arr_word,
  input  logic               done,
  input  logic [ADDR_W-1:0]  rd_addr,
  input  logic [NUM_BLK-1:0] blk_prot,
  output logic [1:0]         read_mode,
  output logic [15:0]        as_data,
  output logic               prog_start,
  output logic               dprog_start,
  output logic [ADDR_W-1:0]  prog_addr,
  output logic [15:0]        prog_data0,
  output logic [15:0]        prog_data1,
  output logic               busy,
  output logic               bypass,
  output logic [15:0]        cfg_word,
  output logic               rp_pdown_en
);

  localparam int CFG_PD_BIT = 10;

  logic ev_pg, ev_dpg0, ev_dpg1, ev_cfg;
  logic as_mode;
  logic same_bank;

  fcd_seq #(.ADDR_W(ADDR_W)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .cmd       (wr_data[7:0]),
    .first_hi  (prog_addr[ADDR_W-1:1]),
    .busy_i    (busy),
    .as_mode_o (as_mode),
    .bypass_o  (bypass),
    .ev_pg     (ev_pg),
    .ev_dpg0   (ev_dpg0),
    .ev_dpg1   (ev_dpg1),
    .ev_cfg    (ev_cfg)
  );

  fcd_prog_latch #(.ADDR_W(ADDR_W)) u_latch (
    .clk         (clk),
    .rst_n       (rst_n),
    .ev_pg       (ev_pg),
    .ev_dpg0     (ev_dpg0),
    .ev_dpg1     (ev_dpg1),
    .done        (done),
    .wr_addr     (wr_addr),
    .wr_data     (wr_data),
    .arr_word    (arr_word),
    .prog_addr   (prog_addr),
    .prog_data0  (prog_data0),
    .prog_data1  (prog_data1),
    .prog_start  (prog_start),
    .dprog_start (dprog_start),
    .busy        (busy)
  );

  fcd_cfg_reg u_cfg (
    .clk      (clk),
    .rst_n    (rst_n),
    .ev_cfg   (ev_cfg),
    .load_val (wr_addr[15:0]),
    .cfg_q    (cfg_word)
  );

  fcd_asel_mux #(
    .ADDR_W   (ADDR_W),
    .BLK_LSB  (BLK_LSB),
    .MFR_CODE (MFR_CODE),
    .DEV_CODE (DEV_CODE)
  ) u_asel (
    .rd_addr  (rd_addr),
    .blk_prot (blk_prot),
    .cfg_q    (cfg_word),
    .as_data  (as_data)
  );

  assign rp_pdown_en = cfg_word[CFG_PD_BIT];
  assign same_bank   = (rd_addr[ADDR_W-1 -: BANK_W] == prog_addr[ADDR_W-1 -: BANK_W]);

  always_comb begin
    if (busy && same_bank) read_mode = RD_STATUS;
    else if (as_mode)      read_mode = RD_ASEL;
    else                   read_mode = RD_ARRAY;
  end

  // R12: status is only shown while a program is running
  p_status_needs_busy_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (read_mode == RD_STATUS) |-> busy);

endmodule

// File: tb/flash_cmd_decoder_test.sv
`timescale 1ns/1ps
module flash_cmd_decoder_test;

  localparam int AW = 21;
  localparam int NB = 512;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_en = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [15:0]   wr_data = '0;
  logic [15:0]   arr_word = 16'hFFFF;
  logic          done = 1'b0;
  logic [AW-1:0] rd_addr = '0;
  logic [NB-1:0] blk_prot = '0;
  logic [1:0]    read_mode;
  logic [15:0]   as_data, prog_data0, prog_data1, cfg_word;
  logic          prog_start, dprog_start, busy, bypass, rp_pdown_en;
  logic [AW-1:0] prog_addr;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  flash_cmd_decoder uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .arr_word(arr_word), .done(done), .rd_addr(rd_addr), .blk_prot(blk_prot),
    .read_mode(read_mode), .as_data(as_data), .prog_start(prog_start),
    .dprog_start(dprog_start), .prog_addr(prog_addr), .prog_data0(prog_data0),
    .prog_data1(prog_data1), .busy(busy), .bypass(bypass), .cfg_word(cfg_word),
    .rp_pdown_en(rp_pdown_en)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // One bus write; returns at the falling edge after the sampling edge.
  task automatic bus_wr(input logic [AW-1:0] a, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic unlock(input logic [7:0] c);
    bus_wr(21'h00555, 16'h00AA);
    bus_wr(21'h002AA, 16'h0055);
    bus_wr(21'h00555, {8'h00, c});
  endtask

  task automatic pulse_done();
    @(negedge clk); done = 1'b1;
    @(negedge clk); done = 1'b0;
  endtask

  task automatic t_reset();
    check("R1 read_mode", read_mode, 2'd0);
    check("R1 busy", busy, 1'b0);
    check("R1 bypass", bypass, 1'b0);
    check("R1 cfg", cfg_word, 16'h0000);
    check("R1 strobes", {prog_start, dprog_start}, 2'b00);
  endtask

  task automatic t_autosel();
    blk_prot[5] = 1'b1;
    unlock(8'h90);
    check("R4 mode", read_mode, 2'd1);
    rd_addr = 21'h1F000; #1;
    check("R4 mfr", as_data, 16'h0020);
    rd_addr = 21'h00001; #1;
    check("R4 dev", as_data, 16'h00A0);
    rd_addr = 21'h00004; #1;
    check("R4 pad bits", as_data, 16'h0000);
    rd_addr = (21'd5 << 12) | 21'd2; #1;
    check("R5 protected", as_data, 16'h0001);
    rd_addr = (21'd6 << 12) | 21'd2; #1;
    check("R5 unprotected", as_data, 16'h0000);
    bus_wr(21'h00000, 16'h00F0);
    check("R13 exit identify", read_mode, 2'd0);
  endtask

  task automatic t_cfg();
    unlock(8'h60);
    bus_wr(21'h00400, 16'h0003);
    check("R6 cfg load", cfg_word, 16'h0400);
    check("R6 pdown", rp_pdown_en, 1'b1);
    unlock(8'h60);
    bus_wr(21'h0FFFF, 16'h0005);
    check("R6 bad confirm", cfg_word, 16'h0400);
    unlock(8'h90);
    rd_addr = 21'h00003; #1;
    check("R6 cfg read", as_data, 16'h0400);
    bus_wr(21'h00000, 16'h00F0);
  endtask

  task automatic t_abort();
    bus_wr(21'h00555, 16'h00AA);
    bus_wr(21'h00123, 16'h0055);
    bus_wr(21'h00555, 16'h00A0);
    bus_wr(21'h00100, 16'h0000);
    check("R3 no strobe", {prog_start, busy}, 2'b00);
    check("R3 mode", read_mode, 2'd0);
    check("R3 cfg kept", cfg_word, 16'h0400);
  endtask

  task automatic t_program();
    arr_word = 16'hF0F0;
    bus_wr(21'h10555, 16'hAB_AA);
    bus_wr(21'h002AA, 16'h0055);
    bus_wr(21'h00555, 16'h00A0);
    bus_wr(21'h01234, 16'hFF00);
    check("R7 start", prog_start, 1'b1);
    check("R2 high bits ignored", prog_addr, 21'h01234);
    check("R7 merged", prog_data0, 16'hF000);
    check("R11 busy", busy, 1'b1);
    rd_addr = 21'h00010; #1;
    check("R12 same bank", read_mode, 2'd2);
    rd_addr = 21'h100010; #1;
    check("R12 other bank", read_mode, 2'd0);
    @(negedge clk);
    check("R7 one cycle", prog_start, 1'b0);
    unlock(8'h90);
    check("R11 still busy", busy, 1'b1);
    pulse_done();
    check("R11 done", busy, 1'b0);
    check("R11 writes ignored", read_mode, 2'd0);
    arr_word = 16'hFFFF;
  endtask

  task automatic t_dword();
    unlock(8'h40);
    bus_wr(21'h00200, 16'h1234);
    check("R8 no early strobe", dprog_start, 1'b0);
    bus_wr(21'h00201, 16'h5678);
    check("R8 start", dprog_start, 1'b1);
    check("R8 addr", prog_addr, 21'h00200);
    check("R8 data0", prog_data0, 16'h1234);
    check("R8 data1", prog_data1, 16'h5678);
    pulse_done();
    unlock(8'h40);
    bus_wr(21'h00200, 16'h1111);
    bus_wr(21'h00400, 16'h2222);
    check("R8 pair mismatch", {dprog_start, busy}, 2'b00);
  endtask

  task automatic t_bypass();
    unlock(8'h20);
    check("R9 enter", bypass, 1'b1);
    arr_word = 16'h0F0F;
    bus_wr(21'h07777, 16'h00A0);
    bus_wr(21'h00345, 16'h00FF);
    check("R9 short program", prog_start, 1'b1);
    check("R9 merged", prog_data0, 16'h000F);
    pulse_done();
    arr_word = 16'hFFFF;
    bus_wr(21'h00000, 16'h0040);
    bus_wr(21'h00010, 16'hAAAA);
    bus_wr(21'h00011, 16'h5555);
    check("R9 short dword", dprog_start, 1'b1);
    pulse_done();
    bus_wr(21'h00000, 16'h0090);
    bus_wr(21'h00000, 16'h0055);
    check("R10 bad confirm", bypass, 1'b1);
    bus_wr(21'h00000, 16'h0090);
    bus_wr(21'h00000, 16'h0000);
    check("R10 exit", bypass, 1'b0);
    check("R10 array", read_mode, 2'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_autosel();
    t_cfg();
    t_abort();
    t_program();
    t_dword();
    t_bypass();
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule